// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Unit

This block sits between an interrupt delivery path and a processor core. It keeps three 256-bit vectors, each with one bit per interrupt vector number. The request vector holds vectors that have arrived and wait for service. The in-service vector holds vectors the core has taken and not yet retired. The trigger vector records whether each pending vector arrived level-sensitive or edge-sensitive. An 8-bit priority threshold register sits beside them. Every cycle the block decides whether the highest waiting vector should be presented to the core.

A delivery carries a vector number and a trigger kind. When the core acknowledges, the winning vector moves from request to in-service and is handed back on `ack_vector`. Software retires the most urgent in-service vector by writing to the end-of-interrupt location. When that vector was level-triggered, a one-cycle notice carrying the vector number goes back to the I/O side, so the source can re-arm. A 32-bit register port exposes the threshold, a spurious-vector word, a fixed version word and the three vectors as eight 32-bit words each.

Top module: `vec_accept_unit`

## Requirements
- R1: A delivery of a legal vector V whose request bit is clear sets request bit V, and sets trigger bit V to 1 for level and 0 for edge. A delivery of V while request bit V is already set changes nothing.
- R2: A delivery of a vector below 0x10, or of 0xFF, is discarded and changes no state.
- R3: `irq_pending` is 1 exactly when three conditions hold. Some request bit is set. The highest set request bit is above the highest set in-service bit, where an empty in-service vector counts as -1. Bits 7:4 of that request vector are strictly greater than bits 7:4 of the threshold register.
- R4: While `irq_pending` is 1, `ack_vector` shows the highest request vector. An `ack` pulse in that cycle clears it from request and sets it in in-service at the next edge. An `ack` while `irq_pending` is 0 changes nothing.
- R5: A write to offset 0xB0 clears the highest set in-service bit. If that vector's trigger bit is 1, `eoi_out_valid` is 1 for the one cycle after the write edge, with `eoi_out_vector` equal to the vector. Otherwise `eoi_out_valid` stays 0.
- R6: A write to 0xB0 while no in-service bit is set changes no state and raises no notice.
- R7: The threshold register at offset 0x80 stores bits 7:0 of the write data and reads back zero-extended.
- R8: Reads return the in-service words at 0x100+16*i, the trigger words at 0x180+16*i and the request words at 0x200+16*i, for i = 0..7. Word i holds vectors 32i..32i+31, and vector 32i+b sits at bit b.
- R9: Offset 0xF0 resets to 0x000000FE and holds a full 32-bit write. Offset 0x30 always reads 0x00050014. Unmapped offsets read 0.
- R10: After reset all three vectors and the threshold are 0, `irq_pending` is 0 and `eoi_out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dlv_valid | input | 1 | Delivery strobe |
| dlv_vector | input | 8 | Delivered vector number |
| dlv_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack | input | 1 | Core acknowledge |
| irq_pending | output | 1 | Interrupt presented to the core |
| ack_vector | output | 8 | Highest request vector |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| eoi_out_valid | output | 1 | End-of-interrupt notice to the I/O side |
| eoi_out_vector | output | 8 | Vector carried by the notice |

## Verification
The assertions check on every cycle the state changes around each event. They cover how an accepted delivery sets request and trigger bits, and how illegal or duplicate deliveries leave the vectors alone. They also cover the move from request to in-service on acknowledge, the retiring of the in-service bit on end-of-interrupt, the notice that follows only for level vectors, and the threshold store. The bench adds what needs a whole history to judge. That covers the pending decision when the in-service and threshold conditions interact, the ordering of vectors retired by successive end-of-interrupt writes, and the word and bit layout seen through register reads. It checks these against a model of the three vectors, driven by random mixes of deliveries, acknowledges, threshold writes and end-of-interrupt writes.

// File: rtl/vec_accept_pkg.sv
package vec_accept_pkg;
  localparam int NUM_VEC   = 256;
  localparam int VEC_W     = $clog2(NUM_VEC);
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = NUM_VEC / WORD_W;
  localparam int ADDR_W    = 12;

  localparam logic [ADDR_W-1:0] OFS_VERSION  = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_THRESH   = 12'h080;
  localparam logic [ADDR_W-1:0] OFS_EOI      = 12'h0B0;
  localparam logic [ADDR_W-1:0] OFS_SPURIOUS = 12'h0F0;
  localparam logic [ADDR_W-1:0] OFS_INSVC    = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_TRIG     = 12'h180;
  localparam logic [ADDR_W-1:0] OFS_REQ      = 12'h200;

  localparam logic [WORD_W-1:0] VERSION_WORD  = 32'h0005_0014;
  localparam logic [WORD_W-1:0] SPURIOUS_INIT = 32'h0000_00FE;

  // A vector may be delivered only if it is outside the reserved low range
  // and is not the all-ones value.
  function automatic logic vec_legal(input logic [VEC_W-1:0] v);
    return (v >= VEC_W'(16)) && (v != {VEC_W{1'b1}});
  endfunction

  // Priority class: the upper four bits of a vector number.
  function automatic logic [3:0] class_of(input logic [VEC_W-1:0] v);
    return v[VEC_W-1 -: 4];
  endfunction
endpackage

// File: rtl/acc_prio_enc.sv
module acc_prio_enc #(
  parameter int N  = 256,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits_in,
  output logic [IW-1:0] top_idx,
  output logic          any_set
);
  always_comb begin
    top_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (bits_in[i]) top_idx = IW'(i);
    end
  end
  assign any_set = |bits_in;
endmodule

// File: rtl/acc_vec_bank.sv
module acc_vec_bank
  import vec_accept_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_req,
  input  logic [VEC_W-1:0]   set_vec,
  input  logic               set_level,
  input  logic               take,
  input  logic [VEC_W-1:0]   take_vec,
  input  logic               retire,
  input  logic [VEC_W-1:0]   retire_vec,
  output logic [NUM_VEC-1:0] req_q,
  output logic [NUM_VEC-1:0] svc_q,
  output logic [NUM_VEC-1:0] trig_q,
  output logic               dlv_accepted
);
  assign dlv_accepted = set_req && vec_legal(set_vec) && !req_q[set_vec];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      svc_q  <= '0;
      trig_q <= '0;
    end else begin
      if (take) begin
        req_q[take_vec] <= 1'b0;
        svc_q[take_vec] <= 1'b1;
      end
      if (retire) svc_q[retire_vec] <= 1'b0;
      if (dlv_accepted) begin
        req_q[set_vec]  <= 1'b1;
        trig_q[set_vec] <= set_level;
      end
    end
  end

  // R1: accepted delivery lands in request and trigger bits
  p_dlv_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_accepted |=> req_q[$past(set_vec)] && (trig_q[$past(set_vec)] == $past(set_level)));
  // R1: duplicate delivery leaves the trigger bits alone
  p_dup_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && req_q[set_vec]) |=> $stable(trig_q));
  // R2: illegal vector is never recorded
  p_illegal_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && !vec_legal(set_vec) && !req_q[set_vec]) |=> !req_q[$past(set_vec)] && $stable(trig_q));
  // R4: acknowledge moves the vector to in-service
  p_take_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> svc_q[$past(take_vec)] && !req_q[$past(take_vec)]);
  // R5: retire clears the in-service bit
  p_retire_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> !svc_q[$past(retire_vec)]);
endmodule

// File: rtl/acc_reg_read.sv
module acc_reg_read
  import vec_accept_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  input  logic [7:0]         thresh,
  input  logic [WORD_W-1:0]  spurious,
  input  logic [NUM_VEC-1:0] svc_vec,
  input  logic [NUM_VEC-1:0] trig_vec,
  input  logic [NUM_VEC-1:0] req_vec,
  output logic [WORD_W-1:0]  rdata
);
  localparam int WIDX_W = $clog2(NUM_WORDS);

  logic [WIDX_W-1:0] widx;
  logic              aligned;
  logic [ADDR_W-1:0] bank_base;

  assign widx      = addr[4 +: WIDX_W];
  assign aligned   = (addr[3:0] == 4'h0);
  assign bank_base = {addr[ADDR_W-1:4+WIDX_W], {(4+WIDX_W){1'b0}}};

  always_comb begin
    rdata = '0;
    if (aligned) begin
      if (addr == OFS_VERSION)       rdata = VERSION_WORD;
      else if (addr == OFS_THRESH)   rdata = {{(WORD_W-8){1'b0}}, thresh};
      else if (addr == OFS_SPURIOUS) rdata = spurious;
      else if (bank_base == OFS_INSVC) rdata = svc_vec[widx*WORD_W +: WORD_W];
      else if (bank_base == OFS_TRIG)  rdata = trig_vec[widx*WORD_W +: WORD_W];
      else if (bank_base == OFS_REQ)   rdata = req_vec[widx*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/vec_accept_unit.sv
module vec_accept_unit
  import vec_accept_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dlv_valid,
  input  logic [7:0]  dlv_vector,
  input  logic        dlv_level,
  input  logic        ack,
  output logic        irq_pending,
  output logic [7:0]  ack_vector,
  input  logic        reg_wr,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        eoi_out_valid,
  output logic [7:0]  eoi_out_vector
);
  logic [NUM_VEC-1:0] req_q, svc_q, trig_q;
  logic [VEC_W-1:0]   req_hi, svc_hi;
  logic               req_any, svc_any;
  logic               dlv_accepted;
  logic [7:0]         thresh_q;
  logic [WORD_W-1:0]  spurious_q;

  // named internal events
  logic eoi_wr, eoi_take, ack_take, thresh_wr, spur_wr, above_svc, above_thr;

  acc_prio_enc #(.N(NUM_VEC)) u_req_enc (.bits_in(req_q), .top_idx(req_hi), .any_set(req_any));
  acc_prio_enc #(.N(NUM_VEC)) u_svc_enc (.bits_in(svc_q), .top_idx(svc_hi), .any_set(svc_any));

  assign above_svc   = !svc_any || (req_hi > svc_hi);
  assign above_thr   = class_of(req_hi) > thresh_q[7:4];
  assign irq_pending = req_any && above_svc && above_thr;
  assign ack_vector  = req_hi;

  assign ack_take  = ack && irq_pending;
  assign eoi_wr    = reg_wr && (reg_addr == OFS_EOI);
  assign eoi_take  = eoi_wr && svc_any;
  assign thresh_wr = reg_wr && (reg_addr == OFS_THRESH);
  assign spur_wr   = reg_wr && (reg_addr == OFS_SPURIOUS);

  acc_vec_bank u_bank (
    .clk(clk), .rst_n(rst_n),
    .set_req(dlv_valid), .set_vec(dlv_vector), .set_level(dlv_level),
    .take(ack_take), .take_vec(req_hi),
    .retire(eoi_take), .retire_vec(svc_hi),
    .req_q(req_q), .svc_q(svc_q), .trig_q(trig_q),
    .dlv_accepted(dlv_accepted)
  );

  acc_reg_read u_read (
    .addr(reg_addr), .thresh(thresh_q), .spurious(spurious_q),
    .svc_vec(svc_q), .trig_vec(trig_q), .req_vec(req_q),
    .rdata(reg_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thresh_q       <= '0;
      spurious_q     <= SPURIOUS_INIT;
      eoi_out_valid  <= 1'b0;
      eoi_out_vector <= '0;
    end else begin
      if (thresh_wr) thresh_q <= reg_wdata[7:0];
      if (spur_wr)   spurious_q <= reg_wdata;
      eoi_out_valid <= eoi_take && trig_q[svc_hi];
      if (eoi_take)  eoi_out_vector <= svc_hi;
    end
  end

  // R3: a presented vector is never already in service
  p_pend_not_svc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> !svc_q[ack_vector]);
  // R5: level vector retire raises a notice with the vector
  p_eoi_notice_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_take && trig_q[svc_hi]) |=> eoi_out_valid && (eoi_out_vector == $past(svc_hi)));
  // R6: end-of-interrupt with nothing in service raises nothing
  p_eoi_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !svc_any) |=> !eoi_out_valid && $stable(svc_q));
  // R7: threshold keeps the written byte
  p_thresh_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    thresh_wr |=> thresh_q == $past(reg_wdata[7:0]));
  // R5: notice lasts a single cycle unless another retire follows
  p_notice_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_out_valid && !eoi_take) |=> !eoi_out_valid);
endmodule

// File: tb/sim_vec_accept_unit.sv
module sim_vec_accept_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dlv_valid = 1'b0;
  logic [7:0]  dlv_vector = '0;
  logic        dlv_level = 1'b0;
  logic        ack = 1'b0;
  logic        irq_pending;
  logic [7:0]  ack_vector;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eoi_out_valid;
  logic [7:0]  eoi_out_vector;

  always #10 clk = ~clk;

  vec_accept_unit u0 (.*);

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [255:0] m_req = '0, m_svc = '0, m_trig = '0;
  logic [7:0]   m_thr = '0;

  function automatic int hi_of(input logic [255:0] v);
    for (int i = 255; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  function automatic bit m_pend();
    int r, s;
    r = hi_of(m_req); s = hi_of(m_svc);
    if (r < 0 || r <= s) return 0;
    return (r / 16) > (m_thr / 16);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic check_pending(input string tag);
    bit e;
    e = m_pend();
    chk(irq_pending == e, tag, irq_pending, e);
    if (e) chk(ack_vector == 8'(hi_of(m_req)), {tag, " vector"}, ack_vector, hi_of(m_req));
  endtask

  task automatic full_compare(input string tag);
    logic [31:0] d;
    for (int w = 0; w < 8; w++) begin
      rd(12'h100 + 12'(w*16), d); chk(d == m_svc[w*32 +: 32],  {tag, " R8 svc"},  d, m_svc[w*32 +: 32]);
      rd(12'h180 + 12'(w*16), d); chk(d == m_trig[w*32 +: 32], {tag, " R8 trig"}, d, m_trig[w*32 +: 32]);
      rd(12'h200 + 12'(w*16), d); chk(d == m_req[w*32 +: 32],  {tag, " R8 req"},  d, m_req[w*32 +: 32]);
    end
  endtask

  task automatic deliver(input logic [7:0] v, input bit lvl);
    dlv_valid = 1; dlv_vector = v; dlv_level = lvl;
    @(posedge clk); @(negedge clk);
    dlv_valid = 0;
    if (v >= 8'h10 && v != 8'hFF && !m_req[v]) begin m_req[v] = 1; m_trig[v] = lvl; end
  endtask

  task automatic do_ack();
    int h;
    check_pending("R3 before ack");
    ack = 1;
    @(posedge clk); @(negedge clk);
    ack = 0;
    if (m_pend()) begin h = hi_of(m_req); m_req[h] = 0; m_svc[h] = 1; end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic do_eoi();
    int h;
    bit eo;
    h = hi_of(m_svc);
    eo = (h >= 0) && m_trig[h];
    wr(12'h0B0, 32'h0);
    if (h >= 0) m_svc[h] = 0;
    chk(eoi_out_valid == eo, h >= 0 ? "R5 notice" : "R6 no notice", eoi_out_valid, eo);
    if (eo) chk(eoi_out_vector == 8'(h), "R5 notice vector", eoi_out_vector, h);
  endtask

  task automatic set_thr(input logic [31:0] d);
    wr(12'h080, d);
    m_thr = d[7:0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(irq_pending == 0, "R10 pending", irq_pending, 0);
    chk(eoi_out_valid == 0, "R10 notice", eoi_out_valid, 0);
    rd(12'h080, d); chk(d == 0, "R10 threshold", d, 0);
    full_compare("R10");
    // R9 fixed and reset words
    rd(12'h0F0, d); chk(d == 32'hFE, "R9 spurious reset", d, 32'hFE);
    rd(12'h030, d); chk(d == 32'h0005_0014, "R9 version", d, 32'h0005_0014);
    rd(12'h3F0, d); chk(d == 0, "R9 unmapped", d, 0);
    wr(12'h0F0, 32'hDEAD_01FF);
    rd(12'h0F0, d); chk(d == 32'hDEAD_01FF, "R9 spurious write", d, 32'hDEAD_01FF);

    // R1 edge delivery of 0x31: request word 1 bit 17
    deliver(8'h31, 0);
    rd(12'h210, d); chk(d == 32'h0002_0000, "R1 req word", d, 32'h0002_0000);
    check_pending("R3 single");
    // R7 threshold gating, only byte kept
    set_thr(32'hABCD_1230);
    rd(12'h080, d); chk(d == 32'h30, "R7 byte", d, 32'h30);
    check_pending("R3 class equal");
    set_thr(32'h2F);
    check_pending("R3 class below");
    // R4 acknowledge
    chk(ack_vector == 8'h31, "R4 vector", ack_vector, 8'h31);
    do_ack();
    rd(12'h110, d); chk(d == 32'h0002_0000, "R4 svc word", d, 32'h0002_0000);
    check_pending("R4 after ack");
    // R3 lower vector blocked by in-service
    deliver(8'h20, 0);
    check_pending("R3 below svc");
    // R4 ack while not pending ignored
    do_ack();
    full_compare("R4 ignored ack");
    // R1 duplicate level delivery of 0x20 dropped: trigger stays 0
    deliver(8'h20, 1);
    rd(12'h190, d); chk(d == 0, "R1 duplicate trig", d, 0);
    // R2 illegal vectors
    deliver(8'h05, 1); deliver(8'hFF, 1); deliver(8'h0F, 0);
    full_compare("R2 illegal");
    // level 0x45, ack, retire with notice
    deliver(8'h45, 1);
    check_pending("R3 higher");
    do_ack();
    do_eoi();
    do_eoi();
    check_pending("R3 after eoi");
    do_ack();
    do_eoi();
    // R6 retire with nothing in service
    do_eoi();
    full_compare("R6 empty");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = $urandom % 8;
      if (op < 4)      deliver(8'($urandom), 1'($urandom));
      else if (op < 6) do_ack();
      else if (op == 6) do_eoi();
      else             set_thr($urandom & 32'h7F);
      check_pending("R3 random");
      if (n % 50 == 0) full_compare("random");
    end
    full_compare("final");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule